// File: doc/BRIEF.md
# Key-Guarded Watchdog and Interval Timer

This block keeps a free-running 16-bit up-counter that is hidden from the register bus, and watches it for expiry of a selectable interval. Software steers it through one 16-bit control word. A write is accepted only when its upper byte carries the unlock key 0x5A. A write with any other upper byte is treated as a fault and requests a system reset.

In watchdog mode, software must restart the counter before the chosen interval runs out. If it does not, the block pulses a system-reset request, returns its own control bits and counter to their reset values, and leaves a cause flag set so that start-up code can tell a watchdog reset from other resets. In interval-timer mode, expiry sets the same flag instead. An interrupt request follows when the external enable is high. The counter advances on one of two clock-enable inputs, a fast one and a slow one, picked by a control bit. A hold bit freezes the count.

Top module: `wdog_guard`

## Requirements
- R1: After rst_n is released, rd_data reads 0x6900, and sys_rst_req, irq_flag and irq are all 0.
- R2: A write whose wr_data[15:8] equals 0x5A updates the control bits. A write with any other upper byte leaves them unchanged. On the following cycle that write gives a one-cycle sys_rst_req, sets irq_flag, and clears the control bits.
- R3: rd_data[15:8] always reads 0x69. rd_data[7:0] returns the stored control bits, and bit 3 always reads 0.
- R4: Control bits [1:0] pick the interval measured from a restart: 00 gives 2^15 ticks, 01 gives 2^13, 10 gives 2^9 and 11 gives 2^6. Expiry happens on the tick that completes the interval.
- R5: Control bit 2 picks the tick source: 0 uses fast_tick and 1 uses slow_tick. The source that is not selected has no effect.
- R6: A keyed write with bit 3 set restarts the counter at zero. If that write falls on the same cycle as the tick that would expire the interval, the restart wins and no expiry occurs.
- R7: With control bit 4 at 0 (watchdog), expiry produces a one-cycle sys_rst_req and sets irq_flag. The control bits return to 0, and the flag stays set afterwards.
- R8: With control bit 4 at 1 (interval timer), expiry sets irq_flag and does not request a reset. The counter keeps running, so expiry repeats every interval.
- R9: irq is high only while irq_flag is set, irq_enable is high and control bit 4 is 1.
- R10: irq_ack clears irq_flag only in interval-timer mode, and flag_clr clears it in either mode. A flag set in the same cycle as a clear takes priority.
- R11: While control bit 7 is 1, the counter does not advance on any tick. When the bit is cleared, counting resumes from the held value.
- R12: Control bits 5 and 6 are stored and read back, and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| fast_tick | input | 1 | Fast count-enable pulse |
| slow_tick | input | 1 | Slow count-enable pulse |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Write word: key in [15:8], control bits in [7:0] |
| rd_data | output | 16 | Read key 0x69 and stored control bits |
| irq_enable | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| flag_clr | input | 1 | Software clear of the cause flag |
| sys_rst_req | output | 1 | One-cycle system reset request |
| irq_flag | output | 1 | Expiry / reset-cause flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is a keyed restart together with the tick that completes the interval. The second is a flag clear together with an expiring tick. The bench counts the counter up to one tick short of expiry. It then drives the expiring tick in the same cycle as the restart write, or in the same cycle as flag_clr. It judges the outcome from irq_flag on the following cycle: the flag must stay clear after the restart, and it must be set after the clear.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int CNT_W = 16,
  parameter logic [7:0] WR_KEY = 8'h5A,
  parameter logic [7:0] RD_KEY = 8'h69,
  parameter int TAP_A = 15,
  parameter int TAP_B = 13,
  parameter int TAP_C = 9,
  parameter int TAP_D = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fast_tick,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        irq_enable,
  input  logic        irq_ack,
  input  logic        flag_clr,
  output logic        sys_rst_req,
  output logic        irq_flag,
  output logic        irq
);
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  logic [7:0]       ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic             flag_q, rst_q;

  wire key_ok  = wr_data[15:8] == WR_KEY;
  wire wr_good = wr_en & key_ok;
  wire wr_bad  = wr_en & ~key_ok;
  wire kick    = wr_good & wr_data[3];
  wire tick    = ~ctrl[7] & (ctrl[2] ? slow_tick : fast_tick);

  always_comb begin
    case (ctrl[1:0])
      2'b00:   mask = ONES >> (CNT_W - TAP_A);
      2'b01:   mask = ONES >> (CNT_W - TAP_B);
      2'b10:   mask = ONES >> (CNT_W - TAP_C);
      default: mask = ONES >> (CNT_W - TAP_D);
    endcase
  end

  wire wrap    = (cnt & mask) == mask;
  wire expire  = tick & wrap & ~kick;
  wire wd_fire = expire & ~ctrl[4];
  wire tm_fire = expire & ctrl[4];
  wire sys_hit = wd_fire | wr_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cnt    <= '0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= sys_hit;
      if (sys_hit) begin
        ctrl <= '0;
        cnt  <= '0;
      end else begin
        if (wr_good) ctrl <= {wr_data[7:4], 1'b0, wr_data[2:0]};
        if (kick) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
      end
      if (sys_hit | tm_fire) flag_q <= 1'b1;
      else if (flag_clr | (irq_ack & ctrl[4])) flag_q <= 1'b0;
    end
  end

  assign rd_data     = {RD_KEY, ctrl};
  assign sys_rst_req = rst_q;
  assign irq_flag    = flag_q;
  assign irq         = flag_q & irq_enable & ctrl[4];

  AST_BADKEY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] != WR_KEY) |=> (sys_rst_req && irq_flag && rd_data[7:0] == 8'h00)); // R2
  AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] == WR_KEY && wr_data[3]) |=> (cnt == '0)); // R6
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req && !wr_en) |=> !sys_rst_req); // R7
  AST_TIMER_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4] && !wr_en) |=> !sys_rst_req); // R8
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && !wr_en) |=> $stable(cnt)); // R11
endmodule

// File: tb/wdog_guard_test.sv
`timescale 1ns/1ps
module wdog_guard_test;
  logic clk = 0, rst_n = 0;
  logic fast_tick = 0, slow_tick = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic irq_enable = 0, irq_ack = 0, flag_clr = 0;
  logic [15:0] rd_data;
  logic sys_rst_req, irq_flag, irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  wdog_guard uut (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_enable(irq_enable), .irq_ack(irq_ack), .flag_clr(flag_clr),
    .sys_rst_req(sys_rst_req), .irq_flag(irq_flag), .irq(irq));

  // {write word, expected read}
  localparam logic [31:0] VEC [5] = '{
    {16'h5A13, 16'h6913}, {16'h5A1F, 16'h6917}, {16'h5A64, 16'h6964},
    {16'h5AE2, 16'h69E2}, {16'h5A00, 16'h6900}};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(int n, bit slow);
    if (n > 0) begin
      @(negedge clk);
      if (slow) slow_tick = 1; else fast_tick = 1;
      repeat (n) @(negedge clk);
      fast_tick = 0; slow_tick = 0;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd", rd_data, 16'h6900);
    chk("R1 rst/flag/irq", {13'd0, sys_rst_req, irq_flag, irq}, 16'h0);

    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][31:16]);
      chk("R2/R3/R12 readback", rd_data, VEC[i][15:0]);
      chk("R2 no reset on good key", {15'd0, sys_rst_req}, 16'h0);
    end

    wr(16'h5A17);
    wr(16'h1234);
    chk("R2 bad key reset", {14'd0, sys_rst_req, irq_flag}, 16'h3);
    chk("R2 bad key clears ctrl", rd_data, 16'h6900);
    @(negedge clk);
    chk("R2 single pulse", {15'd0, sys_rst_req}, 16'h0);
    pulse_clr();
    chk("R10 flag_clr", {15'd0, irq_flag}, 16'h0);

    wr(16'h5A0B);
    ticks(63, 0);
    chk("R4 tap 2^6 early", {15'd0, sys_rst_req}, 16'h0);
    ticks(1, 0);
    chk("R7 watchdog reset", {14'd0, sys_rst_req, irq_flag}, 16'h3);
    chk("R7 ctrl cleared", rd_data, 16'h6900);
    irq_enable = 1;
    #1 chk("R9 no irq in watchdog", {15'd0, irq}, 16'h0);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R10 ack ignored in watchdog", {15'd0, irq_flag}, 16'h1);
    irq_enable = 0;
    pulse_clr();

    wr(16'h5A0A); ticks(511, 0);
    chk("R4 tap 2^9 early", {15'd0, sys_rst_req}, 16'h0);
    ticks(1, 0);
    chk("R4 tap 2^9", {15'd0, sys_rst_req}, 16'h1);
    wr(16'h5A09); ticks(8191, 0);
    chk("R4 tap 2^13 early", {15'd0, sys_rst_req}, 16'h0);
    ticks(1, 0);
    chk("R4 tap 2^13", {15'd0, sys_rst_req}, 16'h1);
    wr(16'h5A08); ticks(32767, 0);
    chk("R4 tap 2^15 early", {15'd0, sys_rst_req}, 16'h0);
    ticks(1, 0);
    chk("R4 tap 2^15", {15'd0, sys_rst_req}, 16'h1);
    pulse_clr();

    wr(16'h5A0F);
    ticks(200, 0);
    chk("R5 fast ignored", {14'd0, sys_rst_req, irq_flag}, 16'h0);
    ticks(63, 1);
    chk("R5 slow early", {15'd0, sys_rst_req}, 16'h0);
    ticks(1, 1);
    chk("R5 slow expiry", {15'd0, sys_rst_req}, 16'h1);
    pulse_clr();

    wr(16'h5A1B);
    ticks(63, 0);
    chk("R8 timer early", {15'd0, irq_flag}, 16'h0);
    ticks(1, 0);
    chk("R8 timer flag no reset", {14'd0, sys_rst_req, irq_flag}, 16'h1);
    chk("R9 irq gated by enable", {15'd0, irq}, 16'h0);
    irq_enable = 1;
    #1 chk("R9 irq", {15'd0, irq}, 16'h1);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R10 ack clears in timer", {14'd0, irq_flag, irq}, 16'h0);
    ticks(63, 0);
    chk("R8 period early", {15'd0, irq_flag}, 16'h0);
    ticks(1, 0);
    chk("R8 period repeat", {15'd0, irq_flag}, 16'h1);
    irq_enable = 0;
    pulse_clr();

    ticks(63, 0);
    @(negedge clk); fast_tick = 1; flag_clr = 1;
    @(negedge clk); fast_tick = 0; flag_clr = 0;
    chk("R10 set wins over clear", {15'd0, irq_flag}, 16'h1);
    pulse_clr();

    ticks(63, 0);
    @(negedge clk); fast_tick = 1; wr_en = 1; wr_data = 16'h5A1B;
    @(negedge clk); fast_tick = 0; wr_en = 0;
    chk("R6 restart beats expiry", {15'd0, irq_flag}, 16'h0);
    ticks(63, 0);
    chk("R6 restart early", {15'd0, irq_flag}, 16'h0);
    ticks(1, 0);
    chk("R6 interval after restart", {15'd0, irq_flag}, 16'h1);
    pulse_clr();

    wr(16'h5A9B);
    chk("R3 bit3 reads 0", rd_data, 16'h6993);
    ticks(200, 0);
    chk("R11 hold freezes", {15'd0, irq_flag}, 16'h0);
    wr(16'h5A13);
    ticks(63, 0);
    chk("R11 resume early", {15'd0, irq_flag}, 16'h0);
    ticks(1, 0);
    chk("R11 resume expiry", {15'd0, irq_flag}, 16'h1);

    finish_up();
  end
endmodule